// File: doc/BRIEF.md
# Parcel-Indexed Next-Fetch-Address Predictor

This block predicts the next fetch address for a front end that fetches aligned blocks of 16-bit parcels and decodes a mix of 16-bit and 32-bit instructions. Each table entry belongs to a single parcel address, not to an instruction start. A 32-bit control transfer keeps its prediction on its second parcel. A 16-bit control transfer keeps it on its only parcel. Because of this, a taken 16-bit branch whose target is PC+4 and a 32-bit instruction that falls through map to different table slots, and the fetch unit can tell the two apart.

A lookup takes one fetch PC and checks every parcel of the aligned block that holds it, in parallel. It returns the predicted next fetch address and the lane of the parcel that produced a taken prediction. A lookup is purely combinational in the PC and the table contents, so one block's prediction never waits on another lookup. Resolved branches train the table through an update port that is written on the clock edge. The table is banked per lane and direct-mapped, with a partial tag.

Top module: `nap_parcel_predictor`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses: `lk_hit_o`=0, `lk_slot_o`=0, and the sequential next-block address is returned.
- R2: On a miss, `lk_next_o` is the start of the next aligned fetch block. With the defaults that is (pc & ~7) + 8, since 4 parcels make 8 bytes. `lk_slot_o` is 0 on a miss.
- R3: A taken update of a 16-bit branch (`upd_wide_i`=0) at byte address P writes the entry for parcel P. A later lookup of P's block, with a fetch PC at or before P, hits with `lk_slot_o`=P[2:1] and `lk_next_o` equal to the target with bit 0 forced to 0.
- R4: A taken update of a 32-bit branch (`upd_wide_i`=1) at P writes the entry for parcel P+2. When P is the last parcel of a block, that entry therefore belongs to lane 0 of the following block.
- R5: A taken 16-bit branch at P with target P+4 reports a hit at lane P[2:1] with next address P+4. A block whose parcels were never trained reports a miss.
- R6: Entries in lanes below the fetch PC's lane (pc[2:1]) are ignored.
- R7: When several lanes at or after the fetch lane hit, the lowest-numbered lane wins.
- R8: A not-taken update invalidates the slot that the branch's last parcel maps to, whatever tag that slot holds.
- R9: The slot is chosen by lane = pc[2:1] and set = pc[6:3], and the tag is pc[14:7] (with the defaults). A stored tag that differs from the lookup's tag is a miss, and a taken update to the same lane and set replaces the older entry.
- R10: An update takes effect at the clock edge on which `upd_valid_i` is sampled. A lookup in that same cycle still sees the old contents.
- R11: Bit 0 of `lk_next_o` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lk_pc_i | input | ADDR_W | Fetch PC to look up (bit 0 ignored) |
| lk_hit_o | output | 1 | A taken prediction was found in the block |
| lk_slot_o | output | LANE_W | Lane of the predicting parcel, 0 on miss |
| lk_next_o | output | ADDR_W | Predicted next fetch address |
| upd_valid_i | input | 1 | Training update strobe |
| upd_pc_i | input | ADDR_W | Start address of the resolved branch |
| upd_wide_i | input | 1 | Branch is a 32-bit instruction |
| upd_taken_i | input | 1 | Branch resolved taken |
| upd_target_i | input | ADDR_W | Resolved target address |

## Verification
The hardest condition to reach from the ports is a tag conflict between two branches that share a lane and a set: one replaces the other, and the victim's block then has to fall back to the sequential address. Directed cases set this up with two addresses exactly 128 bytes apart. They also place a 32-bit branch on the last parcel of a block so that its entry lands in the next block. Random training and lookups are confined to a 512-byte window, which holds four tags per slot. This produces frequent aliasing, clears and lane-priority races, and a bench-side table model checks each result.

// File: rtl/nap_pkg.sv
package nap_pkg;
  typedef enum logic [1:0] {
    NAP_OP_IDLE  = 2'd0,
    NAP_OP_WRITE = 2'd1,
    NAP_OP_CLEAR = 2'd2
  } nap_op_e;
endpackage

// File: rtl/nap_lane_bank.sv
module nap_lane_bank
  import nap_pkg::*;
#(
  parameter int SET_W = 4,
  parameter int TAG_W = 8,
  parameter int TGT_W = 31
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SET_W-1:0] rd_set_i,
  input  logic [TAG_W-1:0] rd_tag_i,
  output logic             rd_hit_o,
  output logic [TGT_W-1:0] rd_tgt_o,
  input  nap_op_e          wr_op_i,
  input  logic [SET_W-1:0] wr_set_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic [TGT_W-1:0] wr_tgt_i
);
  localparam int SETS = 1 << SET_W;

  logic [SETS-1:0]  valid_q;
  logic [TAG_W-1:0] tag_q [SETS];
  logic [TGT_W-1:0] tgt_q [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else begin
      case (wr_op_i)
        NAP_OP_WRITE: valid_q[wr_set_i] <= 1'b1;
        NAP_OP_CLEAR: valid_q[wr_set_i] <= 1'b0;
        default: ;
      endcase
    end
  end

  // payload needs no reset: guarded by valid_q
  always_ff @(posedge clk_i) begin
    if (wr_op_i == NAP_OP_WRITE) begin
      tag_q[wr_set_i] <= wr_tag_i;
      tgt_q[wr_set_i] <= wr_tgt_i;
    end
  end

  assign rd_hit_o = valid_q[rd_set_i] && (tag_q[rd_set_i] == rd_tag_i);
  assign rd_tgt_o = tgt_q[rd_set_i];
endmodule

// File: rtl/nap_slot_select.sv
module nap_slot_select #(
  parameter int LANE_W = 2
) (
  input  logic [(1<<LANE_W)-1:0] hit_vec_i,
  input  logic [LANE_W-1:0]      start_i,
  output logic                   sel_valid_o,
  output logic [LANE_W-1:0]      sel_idx_o
);
  localparam int PARCELS = 1 << LANE_W;

  // lowest lane at or after the fetch lane
  always_comb begin
    sel_valid_o = 1'b0;
    sel_idx_o   = '0;
    for (int i = 0; i < PARCELS; i++) begin
      if (!sel_valid_o && hit_vec_i[i] && (LANE_W'(i) >= start_i)) begin
        sel_valid_o = 1'b1;
        sel_idx_o   = LANE_W'(i);
      end
    end
  end
endmodule

// File: rtl/nap_parcel_predictor.sv
module nap_parcel_predictor
  import nap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LANE_W = 2,
  parameter int SET_W  = 4,
  parameter int TAG_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] lk_pc_i,
  output logic              lk_hit_o,
  output logic [LANE_W-1:0] lk_slot_o,
  output logic [ADDR_W-1:0] lk_next_o,
  input  logic              upd_valid_i,
  input  logic [ADDR_W-1:0] upd_pc_i,
  input  logic              upd_wide_i,
  input  logic              upd_taken_i,
  input  logic [ADDR_W-1:0] upd_target_i
);
  localparam int PARCELS = 1 << LANE_W;
  localparam int PA_W    = ADDR_W - 1;
  localparam int SET_LO  = LANE_W;
  localparam int TAG_LO  = LANE_W + SET_W;
  localparam int BLK_W   = PA_W - LANE_W;

  // parcel addresses
  logic [PA_W-1:0]   lk_pa, up_pa;
  logic [SET_W-1:0]  lk_set, up_set;
  logic [TAG_W-1:0]  lk_tag, up_tag;
  logic [LANE_W-1:0] lk_start, up_lane;

  assign lk_pa    = lk_pc_i[ADDR_W-1:1];
  assign lk_set   = lk_pa[TAG_LO-1:SET_LO];
  assign lk_tag   = lk_pa[TAG_LO+TAG_W-1:TAG_LO];
  assign lk_start = lk_pa[LANE_W-1:0];

  // a 32-bit branch trains its second parcel
  assign up_pa   = upd_pc_i[ADDR_W-1:1] + PA_W'(upd_wide_i);
  assign up_set  = up_pa[TAG_LO-1:SET_LO];
  assign up_tag  = up_pa[TAG_LO+TAG_W-1:TAG_LO];
  assign up_lane = up_pa[LANE_W-1:0];

  logic [PARCELS-1:0] hit_vec;
  logic [PA_W-1:0]    lane_tgt [PARCELS];

  for (genvar l = 0; l < PARCELS; l++) begin : g_lane
    nap_op_e op;
    always_comb begin
      op = NAP_OP_IDLE;
      if (upd_valid_i && (up_lane == LANE_W'(l)))
        op = upd_taken_i ? NAP_OP_WRITE : NAP_OP_CLEAR;
    end

    nap_lane_bank #(
      .SET_W (SET_W),
      .TAG_W (TAG_W),
      .TGT_W (PA_W)
    ) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .rd_set_i (lk_set),
      .rd_tag_i (lk_tag),
      .rd_hit_o (hit_vec[l]),
      .rd_tgt_o (lane_tgt[l]),
      .wr_op_i  (op),
      .wr_set_i (up_set),
      .wr_tag_i (up_tag),
      .wr_tgt_i (upd_target_i[ADDR_W-1:1])
    );
  end

  logic              sel_valid;
  logic [LANE_W-1:0] sel_idx;

  nap_slot_select #(.LANE_W(LANE_W)) u_sel (
    .hit_vec_i   (hit_vec),
    .start_i     (lk_start),
    .sel_valid_o (sel_valid),
    .sel_idx_o   (sel_idx)
  );

  logic [PA_W-1:0] seq_pa;
  assign seq_pa = {lk_pa[PA_W-1:LANE_W] + BLK_W'(1), {LANE_W{1'b0}}};

  assign lk_hit_o  = sel_valid;
  assign lk_slot_o = sel_valid ? sel_idx : '0;
  assign lk_next_o = {(sel_valid ? lane_tgt[sel_idx] : seq_pa), 1'b0};
endmodule

// File: rtl/nap_parcel_predictor_chk.sv
module nap_parcel_predictor_chk #(
  parameter int ADDR_W = 32,
  parameter int LANE_W = 2,
  parameter int SET_W  = 4,
  parameter int TAG_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] lk_pc_i,
  input logic              lk_hit_o,
  input logic [LANE_W-1:0] lk_slot_o,
  input logic [ADDR_W-1:0] lk_next_o,
  input logic              upd_valid_i,
  input logic [ADDR_W-1:0] upd_pc_i,
  input logic              upd_wide_i,
  input logic              upd_taken_i,
  input logic [ADDR_W-1:0] upd_target_i
);
  localparam int HI_W = ADDR_W - LANE_W - 1;

  logic [ADDR_W-1:0] up_byte;
  logic [ADDR_W-1:0] seq_byte;
  assign up_byte  = upd_pc_i + (upd_wide_i ? ADDR_W'(2) : ADDR_W'(0));
  assign seq_byte = {lk_pc_i[ADDR_W-1:LANE_W+1] + HI_W'(1), {(LANE_W+1){1'b0}}};

  a_r11_next_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_next_o[0] == 1'b0);

  a_r2_miss_sequential: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_hit_o |-> (lk_next_o == seq_byte) && (lk_slot_o == '0));

  a_r6_slot_not_before_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> lk_slot_o >= lk_pc_i[LANE_W:1]);

  a_r3_write_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_taken_i) |=>
      ((lk_pc_i[ADDR_W-1:1] != $past(up_byte[ADDR_W-1:1])) ||
       (lk_hit_o && lk_slot_o == $past(up_byte[LANE_W:1]) &&
        lk_next_o == {$past(upd_target_i[ADDR_W-1:1]), 1'b0})));

  a_r8_clear_effective: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && !upd_taken_i) |=>
      ((lk_pc_i[ADDR_W-1:1] != $past(up_byte[ADDR_W-1:1])) ||
       !(lk_hit_o && lk_slot_o == lk_pc_i[LANE_W:1])));
endmodule

bind nap_parcel_predictor nap_parcel_predictor_chk #(
  .ADDR_W (ADDR_W),
  .LANE_W (LANE_W),
  .SET_W  (SET_W),
  .TAG_W  (TAG_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .lk_pc_i      (lk_pc_i),
  .lk_hit_o     (lk_hit_o),
  .lk_slot_o    (lk_slot_o),
  .lk_next_o    (lk_next_o),
  .upd_valid_i  (upd_valid_i),
  .upd_pc_i     (upd_pc_i),
  .upd_wide_i   (upd_wide_i),
  .upd_taken_i  (upd_taken_i),
  .upd_target_i (upd_target_i)
);

// File: tb/nap_parcel_predictor_test.sv
`timescale 1ns/1ps
module nap_parcel_predictor_test;
  localparam int ADDR_W = 32;
  localparam int LANE_W = 2;
  localparam int SET_W  = 4;
  localparam int TAG_W  = 8;
  localparam int PARCELS = 1 << LANE_W;
  localparam int SETS    = 1 << SET_W;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [ADDR_W-1:0] lk_pc_i = '0;
  logic              lk_hit_o;
  logic [LANE_W-1:0] lk_slot_o;
  logic [ADDR_W-1:0] lk_next_o;
  logic              upd_valid_i = 1'b0;
  logic [ADDR_W-1:0] upd_pc_i = '0;
  logic              upd_wide_i = 1'b0;
  logic              upd_taken_i = 1'b0;
  logic [ADDR_W-1:0] upd_target_i = '0;

  always #10 clk_i = ~clk_i;

  nap_parcel_predictor #(
    .ADDR_W(ADDR_W), .LANE_W(LANE_W), .SET_W(SET_W), .TAG_W(TAG_W)
  ) uut (.*);

  int checks = 0;
  int fails  = 0;

  bit                m_v   [PARCELS][SETS];
  logic [TAG_W-1:0]  m_tag [PARCELS][SETS];
  logic [ADDR_W-1:0] m_tgt [PARCELS][SETS];

  function automatic logic [ADDR_W-1:0] pa_of(input logic [ADDR_W-1:0] a);
    return a >> 1;
  endfunction

  task automatic model_update(input logic [ADDR_W-1:0] pc, input bit wide,
                              input bit taken, input logic [ADDR_W-1:0] tgt);
    logic [ADDR_W-1:0] pa = pa_of(pc) + (wide ? 1 : 0);
    int lane = int'(pa[LANE_W-1:0]);
    int set  = int'(pa[LANE_W+SET_W-1:LANE_W]);
    m_v[lane][set] = taken;
    if (taken) begin
      m_tag[lane][set] = pa[LANE_W+SET_W+TAG_W-1:LANE_W+SET_W];
      m_tgt[lane][set] = {tgt[ADDR_W-1:1], 1'b0};
    end
  endtask

  task automatic model_lookup(input logic [ADDR_W-1:0] pc, output bit hit,
                              output logic [LANE_W-1:0] slot,
                              output logic [ADDR_W-1:0] nxt);
    logic [ADDR_W-1:0] pa = pa_of(pc);
    int set = int'(pa[LANE_W+SET_W-1:LANE_W]);
    logic [TAG_W-1:0] tag = pa[LANE_W+SET_W+TAG_W-1:LANE_W+SET_W];
    hit = 1'b0; slot = '0;
    nxt = ((pc >> (LANE_W+1)) + 1) << (LANE_W+1);
    for (int l = int'(pa[LANE_W-1:0]); l < PARCELS; l++) begin
      if (!hit && m_v[l][set] && m_tag[l][set] == tag) begin
        hit = 1'b1; slot = LANE_W'(l); nxt = m_tgt[l][set];
      end
    end
  endtask

  task automatic check(input string req, input bit e_hit,
                       input logic [LANE_W-1:0] e_slot, input logic [ADDR_W-1:0] e_nxt);
    checks++;
    if (lk_hit_o !== e_hit || lk_slot_o !== e_slot || lk_next_o !== e_nxt) begin
      fails++;
      $display("FAIL %s pc=%h: hit/slot/next actual %0b/%0d/%h expected %0b/%0d/%h",
               req, lk_pc_i, lk_hit_o, lk_slot_o, lk_next_o, e_hit, e_slot, e_nxt);
    end
  endtask

  task automatic look(input string req, input logic [ADDR_W-1:0] pc);
    bit h; logic [LANE_W-1:0] s; logic [ADDR_W-1:0] n;
    @(negedge clk_i);
    lk_pc_i = pc;
    #1;
    model_lookup(pc, h, s, n);
    check(req, h, s, n);
  endtask

  task automatic train(input logic [ADDR_W-1:0] pc, input bit wide,
                       input bit taken, input logic [ADDR_W-1:0] tgt);
    @(negedge clk_i);
    upd_valid_i = 1'b1; upd_pc_i = pc; upd_wide_i = wide;
    upd_taken_i = taken; upd_target_i = tgt;
    @(posedge clk_i);
    #1;
    upd_valid_i = 1'b0;
    model_update(pc, wide, taken, tgt);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed = 32'h0000_5eed;
    void'($urandom(seed));
    for (int l = 0; l < PARCELS; l++)
      for (int s = 0; s < SETS; s++) m_v[l][s] = 1'b0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 / R2: empty table, sequential next block
    look("R1", 32'h1000);
    check("R1", 1'b0, 2'd0, 32'h1008);
    look("R2", 32'h1006);
    check("R2", 1'b0, 2'd0, 32'h1008);

    // R3 / R11: 16-bit branch, odd target gets bit 0 dropped
    train(32'h1004, 1'b0, 1'b1, 32'h4001);
    look("R3", 32'h1000);
    check("R3", 1'b1, 2'd2, 32'h4000);
    look("R11", 32'h1004);
    check("R11", 1'b1, 2'd2, 32'h4000);
    // R6: fetch lane past the entry
    look("R6", 32'h1006);
    check("R6", 1'b0, 2'd0, 32'h1008);

    // R4: 32-bit branch keyed on second parcel
    train(32'h1010, 1'b1, 1'b1, 32'h5000);
    look("R4", 32'h1010);
    check("R4", 1'b1, 2'd1, 32'h5000);
    // R4: straddling 32-bit branch trains lane 0 of next block
    train(32'h10be, 1'b1, 1'b1, 32'h9000);
    look("R4", 32'h10b8);
    check("R4", 1'b0, 2'd0, 32'h10c0);
    look("R4", 32'h10c0);
    check("R4", 1'b1, 2'd0, 32'h9000);

    // R5: taken compressed to PC+4 versus untrained block
    train(32'h1020, 1'b0, 1'b1, 32'h1024);
    look("R5", 32'h1020);
    check("R5", 1'b1, 2'd0, 32'h1024);
    look("R5", 32'h1030);
    check("R5", 1'b0, 2'd0, 32'h1038);

    // R7: two hits in one block
    train(32'h1016, 1'b0, 1'b1, 32'h6000);
    look("R7", 32'h1010);
    check("R7", 1'b1, 2'd1, 32'h5000);
    look("R7", 32'h1014);
    check("R7", 1'b1, 2'd3, 32'h6000);

    // R8: not-taken clears lane 1 entry only
    train(32'h1010, 1'b1, 1'b0, 32'h0);
    look("R8", 32'h1010);
    check("R8", 1'b1, 2'd3, 32'h6000);

    // R9: alias 128 bytes away, same lane and set, other tag
    look("R9", 32'h1080);
    check("R9", 1'b0, 2'd0, 32'h1088);
    train(32'h1084, 1'b0, 1'b1, 32'h7000);
    look("R9", 32'h1000);
    check("R9", 1'b0, 2'd0, 32'h1008);
    look("R9", 32'h1080);
    check("R9", 1'b1, 2'd2, 32'h7000);

    // R10: same-cycle lookup sees old contents
    @(negedge clk_i);
    lk_pc_i = 32'h10a0;
    upd_valid_i = 1'b1; upd_pc_i = 32'h10a0; upd_wide_i = 1'b0;
    upd_taken_i = 1'b1; upd_target_i = 32'h8000;
    #1;
    check("R10", 1'b0, 2'd0, 32'h10a8);
    @(posedge clk_i);
    #1;
    upd_valid_i = 1'b0;
    model_update(32'h10a0, 1'b0, 1'b1, 32'h8000);
    check("R10", 1'b1, 2'd0, 32'h8000);

    // random mix within a 512-byte window: heavy aliasing
    for (int i = 0; i < 2000; i++) begin
      logic [ADDR_W-1:0] pc = 32'h1000 + ((ADDR_W'($urandom) % 256) << 1);
      if ($urandom % 3 == 0)
        train(pc, 1'($urandom), ($urandom % 4) != 0, ADDR_W'($urandom));
      else
        look("R3/R6/R7/R8/R9 random", pc);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule